// File: doc/BRIEF.md
# Write-Then-Poll Two-Wire Host Sequencer

This block is a host-side controller for a two-wire serial bus. It issues one write command to a serial memory and then finds out when the memory's internal write cycle has finished. The command carries a device select, an address and a few data bytes. The block makes the clock line itself, at a rate set by a parameter, and drives the data line open-drain: it only ever pulls the line low or lets it go.

The write frame closes with a Stop. The block then waits through a bus-free gap and starts polling. Each poll is a Start, one write-direction control byte and a Stop. While the memory is still busy it answers with a not-acknowledge, and the block polls again after another gap. The first acknowledge ends the loop, and `done` pulses with `err` low.

Two things end the command with an error, with `done` pulsing and `err` high:
- a not-acknowledge on any byte of the write frame;
- a run of polls that reaches the limit without an acknowledge.

Top module: `wpoll_host`

## Requirements
- R1: After reset, and whenever idle, `scl_o` is high, `sda_pull` is low (data line released), and `busy`, `done` and `err` are low.
- R2: A request taken while idle produces a write frame sent MSB first, followed by a Stop. The frame is:
  - a Start;
  - the control byte {1010, dev_sel[2:0], 0};
  - the address bits [15:8], then bits [7:0];
  - `nbytes` data bytes (1 to MAX_DATA), where data byte k is `wdata[8k+7:8k]`.
- R3: Every byte is followed by a ninth clock pulse. During that pulse the host keeps the data line released. An acknowledge is the data line sampled low in the middle of that pulse's high time.
- R4: After the write frame, each poll is a separate frame: a Start, the control byte {1010, dev_sel, 0} alone, and a Stop. A not-acknowledge leads to another poll.
- R5: An acknowledged poll ends the command: a Stop, then `done` with `err` low. The number of polls is the number of not-acknowledged polls plus one.
- R6: If MAX_POLLS polls in a row get no acknowledge, the last one ends with a Stop. `done` then pulses with `err` high and no further poll is sent.
- R7: A not-acknowledge on any byte of the write frame ends that frame with a Stop right after that byte. No poll follows, and `done` pulses with `err` high.
- R8: From a Stop (data rising while the clock is high) to the next Start, the bus stays free for at least GAP_CYC + 3·QTR clock cycles.
- R9: While the clock line is low, the host changes `sda_pull` only QTR cycles after the clock fell. While the clock line is high, `sda_pull` changes only to form a Start (from idle) or a Stop.
- R10: Every low period of the clock line lasts exactly 2·QTR cycles.
- R11:
  - `done` is high for one cycle, exactly QTR + GAP_CYC cycles after the final Stop edge.
  - `busy` is high from acceptance until then.
  - `err` is valid with `done`, stays held afterwards, and is cleared when the next request is accepted.
- R12: A request raised while busy is ignored. The bus traffic of the command in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a write-then-poll command (taken when idle) |
| dev_sel | input | 3 | Device select bits of the control byte |
| addr | input | ADDR_W | Memory address sent as two bytes |
| wdata | input | 8·MAX_DATA | Data bytes; byte k in bits [8k+7:8k] |
| nbytes | input | $clog2(MAX_DATA+1) | Number of data bytes, 1 to MAX_DATA |
| sda_in | input | 1 | Level of the data line as seen on the bus |
| scl_o | output | 1 | Clock line level |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command failed; valid with and after `done` |

## Verification
The assertions assume that `sda_in` is a real wired-AND bus level. It is never higher than the host's own pull allows, and a target changes it only while the clock is low. The bench meets both conditions by building `sda_in` as the AND of host and target releases, with a target model that drives or releases only after it has seen a clock fall.

The assertions also assume `nbytes` stays within 1 to MAX_DATA. Every command the bench issues keeps within that range. The bench also changes `addr`, `wdata` and `dev_sel` in the middle of a command only together with a stray request, which the block must ignore.

// File: rtl/wpoll_pkg.sv
package wpoll_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BIT,
    S_STOP,
    S_GAP
  } sym_t;

  // Write-direction control byte: fixed family code, select bits, R/W = 0.
  function automatic logic [7:0] ctrl_byte(input logic [2:0] sel);
    return {4'b1010, sel, 1'b0};
  endfunction

  // Host pull request for one bit slot: slots 0..7 carry the byte MSB first,
  // slot 8 is the acknowledge slot and is always released.
  function automatic logic slot_pull(input logic [7:0] b, input logic [3:0] slot);
    logic [2:0] idx;
    idx = 3'(4'd7 - slot);
    return (slot < 4'd8) ? ~b[idx] : 1'b0;
  endfunction

endpackage

// File: rtl/wpoll_tick.sv
module wpoll_tick #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic       tick,
  output logic [1:0] ph
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(QTR - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      ph  <= 2'd0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= ph + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R10: a quarter phase lasts until its tick, never shorter
  a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> $stable(ph));

endmodule

// File: rtl/wpoll_linemap.sv
module wpoll_linemap
  import wpoll_pkg::*;
(
  input  sym_t       sym,
  input  logic [1:0] ph,
  input  logic       held_lo,
  input  logic       bit_lo,
  output logic       scl,
  output logic       pull
);
  always_comb begin
    scl  = 1'b1;
    pull = 1'b0;
    case (sym)
      S_START: begin
        scl  = 1'b1;
        pull = ph[1];
      end
      S_BIT: begin
        scl  = ph[1];
        pull = (ph == 2'd0) ? held_lo : bit_lo;
      end
      S_STOP: begin
        scl  = ph[1];
        pull = (ph == 2'd0) ? held_lo : (ph != 2'd3);
      end
      default: begin
        scl  = 1'b1;
        pull = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/wpoll_host.sv
module wpoll_host
  import wpoll_pkg::*;
#(
  parameter int QTR       = 4,
  parameter int GAP_CYC   = 8,
  parameter int MAX_POLLS = 6,
  parameter int MAX_DATA  = 4,
  parameter int ADDR_W    = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req,
  input  logic [2:0]                      dev_sel,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [8*MAX_DATA-1:0]           wdata,
  input  logic [$clog2(MAX_DATA+1)-1:0]   nbytes,
  input  logic                            sda_in,
  output logic                            scl_o,
  output logic                            sda_pull,
  output logic                            busy,
  output logic                            done,
  output logic                            err
);
  localparam int NB_W = $clog2(MAX_DATA + 1);
  localparam int BI_W = $clog2(MAX_DATA + 3);
  localparam int PC_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS + 1) : 1;
  localparam int GC_W = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

  sym_t               st;
  logic [3:0]         slot;
  logic [BI_W-1:0]    bidx;
  logic               polling, finish, fail, ack_q, held_lo;
  logic [PC_W-1:0]    poll_cnt;
  logic [GC_W-1:0]    gap_cnt;
  logic [2:0]         sel_q;
  logic [15:0]        addr_q;
  logic [8*MAX_DATA-1:0] data_q;
  logic [NB_W-1:0]    nb_q;

  // named internal events
  logic            tick_w, sym_end, ack_smp, byte_end, gap_end;
  logic [1:0]      ph_w;
  logic [BI_W-1:0] last_idx, didx;
  logic [7:0]      cur_byte;
  logic            bit_lo;

  wpoll_tick #(.QTR(QTR)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st == S_START || st == S_BIT || st == S_STOP),
    .tick (tick_w),
    .ph   (ph_w)
  );

  assign sym_end  = tick_w && (ph_w == 2'd3);
  assign ack_smp  = (st == S_BIT) && (slot == 4'd8) && tick_w && (ph_w == 2'd2);
  assign byte_end = (st == S_BIT) && (slot == 4'd8) && sym_end;
  assign gap_end  = (st == S_GAP) && (gap_cnt == GC_W'(GAP_CYC - 1));
  assign last_idx = BI_W'(nb_q) + BI_W'(2);
  assign didx     = bidx - BI_W'(3);

  always_comb begin
    if (polling || bidx == '0) cur_byte = ctrl_byte(sel_q);
    else if (bidx == BI_W'(1))  cur_byte = addr_q[15:8];
    else if (bidx == BI_W'(2))  cur_byte = addr_q[7:0];
    else                        cur_byte = data_q[{didx, 3'b000} +: 8];
  end

  assign bit_lo = slot_pull(cur_byte, slot);

  wpoll_linemap u_map (
    .sym    (st),
    .ph     (ph_w),
    .held_lo(held_lo),
    .bit_lo (bit_lo),
    .scl    (scl_o),
    .pull   (sda_pull)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_lo <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      if (tick_w)  held_lo <= sda_pull;
      if (ack_smp) ack_q   <= ~sda_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      slot     <= '0;
      bidx     <= '0;
      polling  <= 1'b0;
      finish   <= 1'b0;
      fail     <= 1'b0;
      poll_cnt <= '0;
      gap_cnt  <= '0;
      sel_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      nb_q     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          sel_q    <= dev_sel;
          addr_q   <= 16'(addr);
          data_q   <= wdata;
          nb_q     <= nbytes;
          err      <= 1'b0;
          polling  <= 1'b0;
          finish   <= 1'b0;
          fail     <= 1'b0;
          poll_cnt <= '0;
          bidx     <= '0;
          st       <= S_START;
        end
        S_START: if (sym_end) begin
          st   <= S_BIT;
          slot <= '0;
        end
        S_BIT: if (sym_end) begin
          if (slot != 4'd8) begin
            slot <= slot + 4'd1;
          end else begin
            slot <= '0;
            if (!ack_q) begin
              st <= S_STOP;
              if (!polling || poll_cnt == PC_W'(MAX_POLLS - 1)) begin
                finish <= 1'b1;
                fail   <= 1'b1;
              end else begin
                poll_cnt <= poll_cnt + PC_W'(1);
              end
            end else if (polling) begin
              st     <= S_STOP;
              finish <= 1'b1;
            end else if (bidx == last_idx) begin
              st <= S_STOP;
            end else begin
              bidx <= bidx + BI_W'(1);
            end
          end
        end
        S_STOP: if (sym_end) begin
          st      <= S_GAP;
          gap_cnt <= '0;
        end
        S_GAP: begin
          if (gap_end) begin
            if (finish) begin
              st   <= S_IDLE;
              done <= 1'b1;
              err  <= fail;
            end else begin
              polling <= 1'b1;
              bidx    <= '0;
              st      <= S_START;
            end
          end else begin
            gap_cnt <= gap_cnt + GC_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: completion is reported only once the bus is idle
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && scl_o && !sda_pull));

  // R3: host releases the data line while the acknowledge slot is driven
  a_r3_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && slot == 4'd8 && ph_w != 2'd0) |-> !sda_pull);

  // R9: inside a byte, data is stable while the clock is high
  a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && scl_o && $past(scl_o)) |-> $stable(sda_pull));

  // R6: the poll counter never reaches the limit
  a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PC_W'(MAX_POLLS));

  // R12: the command captured at acceptance is held for its whole life
  a_r12_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q) && $stable(sel_q)));

endmodule

// File: tb/test_wpoll_host.sv
module test_wpoll_host;
  localparam int Q    = 4;
  localparam int GAP  = 8;
  localparam int MAXP = 6;
  localparam int MAXD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  dev_sel = '0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  nbytes = '0;
  logic        sda_in;
  logic        scl_o, sda_pull, busy, done, err;
  logic        tgt_lo = 1'b0;

  always #2 clk = ~clk;

  assign sda_in = ~(sda_pull | tgt_lo);

  wpoll_host #(.QTR(Q), .GAP_CYC(GAP), .MAX_POLLS(MAXP), .MAX_DATA(MAXD), .ADDR_W(16)) i_wpoll_host (
    .clk(clk), .rst_n(rst_n), .req(req), .dev_sel(dev_sel), .addr(addr),
    .wdata(wdata), .nbytes(nbytes), .sda_in(sda_in), .scl_o(scl_o),
    .sda_pull(sda_pull), .busy(busy), .done(done), .err(err)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural target and bus monitor
  logic [2:0] tsel = '0;
  int busy_cfg = 0, busy_left = 0, nack_at = -1;
  logic [7:0] got_q[$];
  int flen_q[$];
  int cur_len = 0;
  bit in_frame = 0, stop_seen = 0, ctrl_ok = 0;
  int bitcnt = 0, bytecnt = 0, low_cnt = 0;
  logic [7:0] shreg = '0;
  longint cyc = 0, stop_t = 0, start_t = 0;
  int done_cnt = 0;
  logic pscl = 1, pline = 1, ppull = 0, pdone = 0;

  always @(negedge clk) begin
    logic s, l, p;
    bit ack;
    cyc++;
    s = scl_o; l = sda_in; p = sda_pull;
    if (rst_n) begin
      if (s && pscl && pline && !l) begin
        if (stop_seen)
          chk(cyc - stop_t >= 3*Q + GAP, "R8 bus free before start", cyc - stop_t, 3*Q + GAP);
        in_frame = 1; bitcnt = 0; bytecnt = 0; cur_len = 0; ctrl_ok = 0;
        start_t = cyc;
      end else if (s && pscl && !pline && l) begin
        if (in_frame) flen_q.push_back(cur_len);
        if (in_frame && ctrl_ok && bytecnt >= 4) busy_left = busy_cfg;
        in_frame = 0; stop_seen = 1; stop_t = cyc;
      end
      if (s && pscl && p != ppull) begin
        if (p) chk(!in_frame || cyc == start_t, "R9 pull rises only as start", p, ppull);
        else   chk(l == 1'b1, "R9 pull falls only as stop", l, 1);
      end
      if (s && !pscl) begin
        chk(low_cnt + 1 == 2*Q, "R10 clock low length", low_cnt + 1, 2*Q);
        if (in_frame) begin
          if (bitcnt < 8) begin shreg = {shreg[6:0], l}; bitcnt++; end
          else if (bitcnt == 8) bitcnt = 9;
        end
      end else if (!s && pscl) begin
        low_cnt = 0;
        if (in_frame && bitcnt == 8) begin
          got_q.push_back(shreg);
          cur_len++;
          if (bytecnt == 0) begin
            ack = (shreg[7:4] == 4'hA) && (shreg[3:1] == tsel) && (busy_left == 0);
            if (!ack && shreg[7:4] == 4'hA && shreg[3:1] == tsel && busy_left > 0) busy_left--;
            ctrl_ok = ack;
          end else begin
            ack = (bytecnt != nack_at);
          end
          tgt_lo = ack;
          bytecnt++;
        end else if (in_frame && bitcnt == 9) begin
          tgt_lo = 1'b0;
          bitcnt = 0;
        end
      end else if (!s) begin
        low_cnt++;
        if (p != ppull) chk(low_cnt == Q, "R9 change at low midpoint", low_cnt, Q);
      end
      if (done) begin
        done_cnt++;
        chk(!pdone, "R11 done one cycle", pdone, 0);
        chk(cyc - stop_t == Q + GAP, "R11 done delay after stop", cyc - stop_t, Q + GAP);
        chk(!busy, "R11 busy low at done", busy, 0);
      end
    end
    pscl = s; pline = l; ppull = p; pdone = done;
  end

  task automatic run_cmd(input logic [2:0] hs, input logic [2:0] ts, input logic [15:0] a,
                         input logic [31:0] d, input int n, input int bz, input int nk,
                         input bit xerr, input int xpolls, input bit inject, input string tag);
    logic [7:0] exp_b[$];
    int d0, w, elen;
    tsel = ts; busy_cfg = bz; busy_left = 0; nack_at = nk;
    got_q.delete(); flen_q.delete();
    @(negedge clk);
    dev_sel = hs; addr = a; wdata = d; nbytes = 3'(n); req = 1'b1;
    d0 = done_cnt;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    chk(err == 1'b0, "R11 err cleared on accept", err, 0);
    if (inject) begin
      repeat (150) @(negedge clk);
      dev_sel = ~hs; addr = ~a; wdata = ~d; nbytes = 3'(1); req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    w = 0;
    while (done_cnt == d0 && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, {tag, " watchdog waiting for done"}, w, 0);
    @(negedge clk);
    chk(err == xerr, {tag, " err"}, err, xerr);
    exp_b.push_back({4'hA, hs, 1'b0});
    exp_b.push_back(a[15:8]);
    exp_b.push_back(a[7:0]);
    for (int k = 0; k < n; k++) exp_b.push_back(d[8*k +: 8]);
    elen = (nk >= 0) ? nk + 1 : 3 + n;
    chk(flen_q.size() == 1 + xpolls, {tag, " frame count"}, flen_q.size(), 1 + xpolls);
    if (flen_q.size() >= 1) begin
      chk(flen_q[0] == elen, {tag, " write frame length"}, flen_q[0], elen);
      for (int k = 0; k < elen && k < got_q.size(); k++)
        chk(got_q[k] == exp_b[k], {tag, " write frame byte"}, got_q[k], exp_b[k]);
    end
    for (int f = 1; f < flen_q.size(); f++)
      chk(flen_q[f] == 1, "R4 poll frame length", flen_q[f], 1);
    for (int k = elen; k < got_q.size(); k++)
      chk(got_q[k] == {4'hA, hs, 1'b0}, "R4 poll control byte", got_q[k], {4'hA, hs, 1'b0});
    chk(scl_o && !sda_pull, "R1 bus idle after command", {scl_o, sda_pull}, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(scl_o == 1 && sda_pull == 0, "R1 reset lines", {scl_o, sda_pull}, 2);
    chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_o == 1 && sda_pull == 0 && !busy, "R1 idle after reset", {scl_o, sda_pull, busy}, 4);

    run_cmd(3'd3, 3'd3, 16'h1234, 32'hA55A_C381, 4, 2, -1, 0, 3, 0, "R2 R5 four bytes busy 2");
    run_cmd(3'd0, 3'd0, 16'hFFFF, 32'h0000_00E7, 1, 0, -1, 0, 1, 0, "R3 R5 one byte no busy");
    run_cmd(3'd6, 3'd6, 16'h0F80, 32'h1122_3344, 3, MAXP - 1, -1, 0, MAXP, 0, "R5 last allowed poll");
    run_cmd(3'd5, 3'd5, 16'h2000, 32'h0000_5AA5, 2, MAXP, -1, 1, MAXP, 0, "R6 poll limit");
    repeat (20) @(negedge clk);
    chk(err == 1'b1 && !done, "R11 err held after done", err, 1);
    run_cmd(3'd2, 3'd5, 16'h0101, 32'h0000_0077, 1, 0, 0, 1, 0, 0, "R7 control nack");
    run_cmd(3'd1, 3'd1, 16'h0203, 32'h0000_9966, 2, 0, 3, 1, 0, 0, "R7 data nack");
    run_cmd(3'd7, 3'd7, 16'h4321, 32'hDEAD_BEEF, 4, 1, -1, 0, 2, 1, "R12 request while busy");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule